// File: doc/BRIEF.md
# Mode Register Programming Unit

This block captures the mode-set command of a low-power DDR memory (in a model or in a controller's shadow copy). It publishes the configuration that the rest of the memory path needs: the burst length, the burst ordering, the read latency, the share of the array that is kept during self refresh, and the output drive strength. On every rising clock edge it samples the four active-low command strobes, the two bank-select bits and a 13-bit operand. A mode-set command is the pattern in which all four strobes are low. The bank-select bits decide which of the two registers the operand goes to.

An operand is checked before it is taken. It is refused when it holds a reserved code, when a bit outside the defined fields is set, or when it targets an undefined register. It is also refused when it arrives while a bank is open or while an earlier write is still settling. A refused write changes nothing and raises a one-cycle error flag that gives the cause. Each accepted write opens a two-cycle busy window. An accepted write to the base register also returns the extended register to its default settings. The base register holds no defined contents until its first write, and a valid flag shows when that write has taken place.

Top module: `mode_reg_unit`

## Requirements
- R1: A write is recognised only when all four command strobes are low at a rising edge. Any other strobe pattern leaves every output unchanged, whatever the bank-select and operand values are.
- R2: A write with bank-select 00 goes to the base register. Operand bits 2..0 give the burst length (001=2, 010=4, 011=8, 100=16), shown as that number on `burst_len`. Bit 3 sets `burst_interleave` (0 = sequential, 1 = interleaved). Bits 6..4 give the read latency (010=2, 011=3), shown as that number on `read_latency`. The outputs change in the cycle after the edge.
- R3: A write with bank-select 10 goes to the extended register. Operand bits 2..0 give the refresh area (000=full → 0, 001=half → 1, 010=quarter → 2 on `refresh_area`). Bits 6..5 give the drive strength code (00 full, 01 half, 10 quarter, 11 eighth), shown unchanged on `drive_strength`.
- R4: A write is refused, and `code_err` is high for exactly the cycle after the edge, in any of these cases: it carries a reserved burst-length, latency or area code; it has a nonzero bit among operand bits 12..7 (either register), or bits 4..3 (extended register); or it uses bank-select 01 or 11. A refused write leaves all fields unchanged.
- R5: Every accepted base-register write also sets the extended register to area full (0) and drive half (01).
- R6: After reset, `base_valid` is 0, `burst_len`, `burst_interleave` and `read_latency` are 0, the extended register holds its default (area 0, drive 01), and `busy`, `code_err` and `state_err` are 0. `base_valid` goes to 1 after the first accepted base write and stays at 1.
- R7: An accepted write holds `busy` high for exactly two cycles after its edge.
- R8: A write that arrives while `banks_idle` is low or `busy` is high is ignored. `state_err` is high for the cycle after it. No field changes and no busy window starts.
- R9: `code_err` and `state_err` are never high together, and neither one rises without a write at the edge before. A blocked write reports only `state_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_sel_n | input | 1 | Command select strobe, active low |
| cmd_row_n | input | 1 | Row command strobe, active low |
| cmd_col_n | input | 1 | Column command strobe, active low |
| cmd_wr_n | input | 1 | Write command strobe, active low |
| bank_sel | input | 2 | Register select during a mode-set command |
| op_code | input | 13 | Operand carried by the mode-set command |
| banks_idle | input | 1 | High when every bank is closed |
| burst_len | output | 5 | Burst length in beats, 0 before first base write |
| burst_interleave | output | 1 | Burst ordering, 1 = interleaved |
| read_latency | output | 2 | Read latency in cycles, 0 before first base write |
| refresh_area | output | 2 | Self-refresh area: 0 full, 1 half, 2 quarter |
| drive_strength | output | 2 | Drive strength code: 0 full, 1 half, 2 quarter, 3 eighth |
| base_valid | output | 1 | Base register has been written since reset |
| busy | output | 1 | Mode-set settle window is open |
| code_err | output | 1 | One-cycle pulse: write refused for a reserved code or target |
| state_err | output | 1 | One-cycle pulse: write refused because banks were open or busy |

## Verification
Some properties are checked on every cycle. A refused write must leave both registers stable. An accepted write must open the busy window, and no write may be accepted while that window is open. Every base write must leave the extended register at its default. The valid flag must stay set once it is set. The two error pulses must never be high together, and each must follow a write. Only the bench's scenarios show the exact decoding of every burst, latency, area and drive code. They also cover the refusal of each reserved encoding and stray bit, and the ordering in which a base write overwrites an extended setting that a user has programmed. Finally they show that non-write strobe patterns carrying legal-looking operands have no effect.

// File: rtl/mode_reg_pkg.sv
package mode_reg_pkg;

    typedef enum logic [1:0] {
        AREA_FULL    = 2'd0,
        AREA_HALF    = 2'd1,
        AREA_QUARTER = 2'd2
    } area_e;

    typedef enum logic [1:0] {
        DRV_FULL    = 2'd0,
        DRV_HALF    = 2'd1,
        DRV_QUARTER = 2'd2,
        DRV_EIGHTH  = 2'd3
    } drive_e;

    typedef struct packed {
        logic [4:0] burst_len;
        logic       interleave;
        logic [1:0] latency;
    } base_cfg_t;

    typedef struct packed {
        area_e  area;
        drive_e drive;
    } ext_cfg_t;

    localparam ext_cfg_t EXT_DEFAULT = '{area: AREA_FULL, drive: DRV_HALF};

    // Burst length in beats; zero marks a reserved code.
    function automatic logic [4:0] burst_from_code(input logic [2:0] code);
        logic [4:0] beats;
        case (code)
            3'b001:  beats = 5'd2;
            3'b010:  beats = 5'd4;
            3'b011:  beats = 5'd8;
            3'b100:  beats = 5'd16;
            default: beats = 5'd0;
        endcase
        return beats;
    endfunction

    // Read latency in cycles; zero marks a reserved code.
    function automatic logic [1:0] latency_from_code(input logic [2:0] code);
        logic [1:0] lat;
        case (code)
            3'b010:  lat = 2'd2;
            3'b011:  lat = 2'd3;
            default: lat = 2'd0;
        endcase
        return lat;
    endfunction

endpackage

// File: rtl/mr_cmd_decode.sv
module mr_cmd_decode (
    input  logic       cmd_sel_n,
    input  logic       cmd_row_n,
    input  logic       cmd_col_n,
    input  logic       cmd_wr_n,
    input  logic [1:0] bank_sel,
    input  logic       banks_idle,
    input  logic       busy,
    output logic       is_write,
    output logic       blocked,
    output logic       to_base,
    output logic       to_ext,
    output logic       to_undef
);
    logic open_path;

    always_comb begin
        is_write  = ~cmd_sel_n & ~cmd_row_n & ~cmd_col_n & ~cmd_wr_n;
        blocked   = is_write & (~banks_idle | busy);
        open_path = is_write & ~blocked;
        to_base   = open_path & (bank_sel == 2'b00);
        to_ext    = open_path & (bank_sel == 2'b10);
        to_undef  = open_path & bank_sel[0];
    end
endmodule

// File: rtl/mr_field_check.sv
module mr_field_check
    import mode_reg_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] op_code,
    output base_cfg_t         base_cfg,
    output logic              base_ok,
    output ext_cfg_t          ext_cfg,
    output logic              ext_ok
);
    localparam int PAD_W = ADDR_W - 7;
    localparam logic [ADDR_W-1:0] BASE_USED = {{PAD_W{1'b0}}, 7'b111_1111};
    localparam logic [ADDR_W-1:0] EXT_USED  = {{PAD_W{1'b0}}, 7'b110_0111};

    logic stray_base;
    logic stray_ext;
    logic area_legal;

    always_comb begin
        base_cfg.burst_len  = burst_from_code(op_code[2:0]);
        base_cfg.interleave = op_code[3];
        base_cfg.latency    = latency_from_code(op_code[6:4]);
        stray_base          = |(op_code & ~BASE_USED);
        base_ok             = (base_cfg.burst_len != 5'd0) &&
                              (base_cfg.latency != 2'd0) && !stray_base;

        ext_cfg.area  = area_e'(op_code[1:0]);
        ext_cfg.drive = drive_e'(op_code[6:5]);
        area_legal    = (op_code[2:0] <= 3'd2);
        stray_ext     = |(op_code & ~EXT_USED);
        ext_ok        = area_legal && !stray_ext;
    end
endmodule

// File: rtl/mr_busy_timer.sv
module mr_busy_timer #(
    parameter int CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (remain_q != '0);
endmodule

// File: rtl/mode_reg_unit.sv
module mode_reg_unit
    import mode_reg_pkg::*;
#(
    parameter int ADDR_W          = 13,
    parameter int MODE_SET_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_sel_n,
    input  logic              cmd_row_n,
    input  logic              cmd_col_n,
    input  logic              cmd_wr_n,
    input  logic [1:0]        bank_sel,
    input  logic [ADDR_W-1:0] op_code,
    input  logic              banks_idle,
    output logic [4:0]        burst_len,
    output logic              burst_interleave,
    output logic [1:0]        read_latency,
    output logic [1:0]        refresh_area,
    output logic [1:0]        drive_strength,
    output logic              base_valid,
    output logic              busy,
    output logic              code_err,
    output logic              state_err
);
    logic      is_write, blocked, to_base, to_ext, to_undef;
    logic      base_ok, ext_ok, take_base, take_ext, accept, refuse_code;
    base_cfg_t base_new, base_q;
    ext_cfg_t  ext_new, ext_q;
    logic      valid_q, code_err_q, state_err_q;

    mr_cmd_decode u_decode (
        .cmd_sel_n (cmd_sel_n),
        .cmd_row_n (cmd_row_n),
        .cmd_col_n (cmd_col_n),
        .cmd_wr_n  (cmd_wr_n),
        .bank_sel  (bank_sel),
        .banks_idle(banks_idle),
        .busy      (busy),
        .is_write  (is_write),
        .blocked   (blocked),
        .to_base   (to_base),
        .to_ext    (to_ext),
        .to_undef  (to_undef)
    );

    mr_field_check #(.ADDR_W(ADDR_W)) u_fields (
        .op_code (op_code),
        .base_cfg(base_new),
        .base_ok (base_ok),
        .ext_cfg (ext_new),
        .ext_ok  (ext_ok)
    );

    mr_busy_timer #(.CYCLES(MODE_SET_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(accept),
        .busy (busy)
    );

    always_comb begin
        take_base   = to_base & base_ok;
        take_ext    = to_ext & ext_ok;
        accept      = take_base | take_ext;
        refuse_code = to_undef | (to_base & ~base_ok) | (to_ext & ~ext_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= '0;
            ext_q       <= EXT_DEFAULT;
            valid_q     <= 1'b0;
            code_err_q  <= 1'b0;
            state_err_q <= 1'b0;
        end else begin
            code_err_q  <= refuse_code;
            state_err_q <= blocked;
            if (take_base) begin
                base_q  <= base_new;
                ext_q   <= EXT_DEFAULT;
                valid_q <= 1'b1;
            end else if (take_ext) begin
                ext_q <= ext_new;
            end
        end
    end

    assign burst_len        = base_q.burst_len;
    assign burst_interleave = base_q.interleave;
    assign read_latency     = base_q.latency;
    assign refresh_area     = ext_q.area;
    assign drive_strength   = ext_q.drive;
    assign base_valid       = valid_q;
    assign code_err         = code_err_q;
    assign state_err        = state_err_q;

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !accept);

    assert_blocked_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (is_write && (busy || !banks_idle)) |=> (state_err && !code_err));

    assert_reject_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (code_err || state_err) |-> ($stable(base_q) && $stable(ext_q)));

    assert_ext_default_R5: assert property (@(posedge clk) disable iff (rst)
        take_base |=> (ext_q == EXT_DEFAULT));

    assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        base_valid |=> base_valid);

    assert_fields_legal_R2: assert property (@(posedge clk) disable iff (rst)
        base_valid |-> ($countones(burst_len) == 1 && burst_len >= 5'd2 &&
                        read_latency >= 2'd2));

    assert_err_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(code_err && state_err));

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (code_err || state_err) |-> $past(is_write));
endmodule

// File: tb/mode_reg_unit_tb_top.sv
module mode_reg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cmd = 4'b0111;
    logic [1:0]  bank_sel = 2'b00;
    logic [12:0] op_code = '0;
    logic        banks_idle = 1'b1;

    logic [4:0] burst_len;
    logic       burst_interleave;
    logic [1:0] read_latency, refresh_area, drive_strength;
    logic       base_valid, busy, code_err, state_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [3:0] WRITE = 4'b0000;
    localparam logic [3:0] NOP   = 4'b0111;
    localparam logic [3:0] REFR  = 4'b0001;
    localparam logic [3:0] DESEL = 4'b1000;

    always #5 clk = ~clk;

    mode_reg_unit dut_i (
        .clk(clk), .rst(rst),
        .cmd_sel_n(cmd[3]), .cmd_row_n(cmd[2]), .cmd_col_n(cmd[1]), .cmd_wr_n(cmd[0]),
        .bank_sel(bank_sel), .op_code(op_code), .banks_idle(banks_idle),
        .burst_len(burst_len), .burst_interleave(burst_interleave),
        .read_latency(read_latency), .refresh_area(refresh_area),
        .drive_strength(drive_strength), .base_valid(base_valid),
        .busy(busy), .code_err(code_err), .state_err(state_err)
    );

    // Bench-side model of the register state.
    logic [4:0] m_bl = 0;
    logic       m_il = 0;
    logic [1:0] m_lat = 0, m_area = 0, m_drv = 2'b01;
    logic       m_valid = 0, m_cerr = 0, m_serr = 0;
    int         m_busy_left = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    function automatic logic [4:0] ref_bl(input logic [2:0] c);
        if (c == 3'd1) return 5'd2;
        if (c == 3'd2) return 5'd4;
        if (c == 3'd3) return 5'd8;
        if (c == 3'd4) return 5'd16;
        return 5'd0;
    endfunction

    function automatic logic [1:0] ref_lat(input logic [2:0] c);
        if (c == 3'd2) return 2'd2;
        if (c == 3'd3) return 2'd3;
        return 2'd0;
    endfunction

    task automatic step(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a,
                        input logic idle, input string tag);
        logic wr, blk, good;
        @(negedge clk);
        cmd = c; bank_sel = b; op_code = a; banks_idle = idle;
        wr   = (c == WRITE);
        blk  = wr && (!idle || m_busy_left > 0);
        m_serr = blk;
        m_cerr = 1'b0;
        good = 1'b0;
        if (wr && !blk) begin
            if (b == 2'b00) begin
                good = ref_bl(a[2:0]) != 0 && ref_lat(a[6:4]) != 0 && a[12:7] == 0;
                if (good) begin
                    m_bl = ref_bl(a[2:0]); m_il = a[3]; m_lat = ref_lat(a[6:4]);
                    m_area = 2'd0; m_drv = 2'b01; m_valid = 1'b1;
                end
            end else if (b == 2'b10) begin
                good = a[2:0] <= 3'd2 && a[12:7] == 0 && a[4:3] == 0;
                if (good) begin
                    m_area = a[1:0]; m_drv = a[6:5];
                end
            end
            m_cerr = !good;
        end
        if (good) m_busy_left = 2;
        else if (m_busy_left > 0) m_busy_left--;
        exp_q.push_back({m_bl, m_il, m_lat, m_area, m_drv, m_valid,
                         (m_busy_left > 0), m_cerr, m_serr});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares one expected item per clock, away from the edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [16:0] exp_v, act_v;
            string t;
            exp_v = exp_q.pop_front();
            t = tag_q.pop_front();
            act_v = {burst_len, burst_interleave, read_latency, refresh_area,
                     drive_strength, base_valid, busy, code_err, state_err};
            checks++;
            if (act_v !== exp_v) begin
                errors++;
                $display("FAIL %s: actual %b expected %b (bl il lat area drv valid busy cerr serr)",
                         t, act_v, exp_v);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(NOP, 2'b00, 13'h0, 1, "R6 reset state");
        // Extended write before any base write.
        step(WRITE, 2'b10, 13'h041, 1, "R3 ext half/quarter");
        step(NOP, 2'b00, 13'h0, 1, "R7 busy cycle 2");
        step(NOP, 2'b00, 13'h0, 1, "R7 busy closed");
        // Base writes across codes; each restores the extended default.
        step(WRITE, 2'b00, 13'h032, 1, "R2 R5 R6 bl4 seq lat3");
        step(NOP, 2'b00, 13'h0, 1, "R7");
        step(NOP, 2'b00, 13'h0, 1, "R7");
        step(WRITE, 2'b00, 13'h029, 1, "R2 bl2 intl lat2");
        step(NOP, 2'b00, 13'h0, 1, "R2");
        step(NOP, 2'b00, 13'h0, 1, "R2");
        step(WRITE, 2'b00, 13'h033, 1, "R2 bl8");
        step(WRITE, 2'b00, 13'h03C, 1, "R8 write while busy");
        step(NOP, 2'b00, 13'h0, 1, "R8");
        step(WRITE, 2'b00, 13'h03C, 1, "R2 bl16 intl");
        step(NOP, 2'b00, 13'h0, 1, "R2");
        step(NOP, 2'b00, 13'h0, 1, "R2");
        step(WRITE, 2'b00, 13'h032, 0, "R8 banks open");
        step(WRITE, 2'b10, 13'h061, 0, "R8 R9 banks open ext");
        // Reserved codes and stray bits.
        step(WRITE, 2'b00, 13'h030, 1, "R4 bl code 000");
        step(WRITE, 2'b00, 13'h035, 1, "R4 bl code 101");
        step(WRITE, 2'b00, 13'h037, 1, "R4 bl code 111");
        step(WRITE, 2'b00, 13'h042, 1, "R4 lat code 100");
        step(WRITE, 2'b00, 13'h012, 1, "R4 lat code 001");
        step(WRITE, 2'b00, 13'h0B2, 1, "R4 base bit7 set");
        step(WRITE, 2'b00, 13'h1032, 1, "R4 base bit12 set");
        step(WRITE, 2'b01, 13'h032, 1, "R4 bank sel 01");
        step(WRITE, 2'b11, 13'h032, 1, "R4 bank sel 11");
        step(WRITE, 2'b10, 13'h003, 1, "R4 area code 011");
        step(WRITE, 2'b10, 13'h008, 1, "R4 ext bit3 set");
        step(WRITE, 2'b10, 13'h010, 1, "R4 ext bit4 set");
        step(WRITE, 2'b10, 13'h200, 1, "R4 ext bit9 set");
        // Drive strengths and areas.
        step(WRITE, 2'b10, 13'h000, 1, "R3 full/full");
        step(NOP, 2'b00, 13'h0, 1, "R3");
        step(NOP, 2'b00, 13'h0, 1, "R3");
        step(WRITE, 2'b10, 13'h022, 1, "R3 half drive quarter area");
        step(NOP, 2'b00, 13'h0, 1, "R3");
        step(NOP, 2'b00, 13'h0, 1, "R3");
        step(WRITE, 2'b10, 13'h061, 1, "R3 eighth drive half area");
        step(NOP, 2'b00, 13'h0, 1, "R3");
        step(NOP, 2'b00, 13'h0, 1, "R3");
        // Non-write strobe patterns carrying legal operands.
        step(REFR, 2'b00, 13'h029, 1, "R1 refresh pattern");
        step(DESEL, 2'b00, 13'h029, 1, "R1 deselected");
        step(4'b0011, 2'b10, 13'h000, 1, "R1 row pattern");
        step(4'b0100, 2'b00, 13'h034, 1, "R1 column pattern");
        // Base write overrides the programmed extended settings.
        step(WRITE, 2'b00, 13'h034, 1, "R5 base restores ext");
        step(NOP, 2'b00, 13'h0, 1, "R5 R9");
        step(NOP, 2'b00, 13'h0, 1, "R5 R6");
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule